// File: doc/BRIEF.md
# Floating-point compare flag unit

The unit takes two 80-bit extended-precision operands and compares them. Each operand has a sign bit, a 15-bit biased exponent and a 64-bit significand with an explicit integer bit. The comparison has four possible results: greater, less, equal and unordered. The unit encodes the result as three integer-style flags (zero, parity, carry), so a conditional branch can use it directly. It also places the same result into a 16-bit legacy condition-code word. Software that tests a mask on that word sees the same four outcomes.

A mode input selects one of two comparison semantics. In ordered mode, any NaN operand raises the invalid-operation flag. In unordered mode, only a signalling NaN raises it. A pop request that arrives with an operand pair produces a one-cycle stack-pop strobe. The strobe comes in the cycle after the result. All results are registered, so a result appears one clock after the valid strobe.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When op_a is greater than op_b, the result is zf=0, pf=0, cf=0.
- R2: When op_a is less than op_b, the result is zf=0, pf=0, cf=1. When the signs differ, the negative operand is the smaller one.
- R3: When the operands are equal, the result is zf=1, pf=0, cf=0. Positive zero and negative zero compare as equal. A zero is an exponent of 0 with a significand of 0.
- R4: When either operand is a NaN, the result is unordered and gives zf=1, pf=1, cf=1. A NaN has exponent 0x7FFF and a nonzero value in significand bits [62:0].
- R5: With mode_unord=0 (ordered), an unordered result raises invalid. An ordered result never raises invalid.
- R6: With mode_unord=1, an unordered result raises invalid only if at least one operand is a signalling NaN. A signalling NaN is a NaN with significand bit 62 clear. A NaN with bit 62 set is quiet and does not raise invalid.
- R7: cc_word carries the result as follows: bit 8 equals cf, bit 10 is set exactly when the result is unordered (mask 0x0400), and bit 14 equals zf. All other bits are 0.
- R8: out_valid is high for exactly the one cycle after a clock edge at which in_valid was sampled high. zf, pf, cf, cc_word and invalid change only at that edge and otherwise hold their last value.
- R9: pop_strobe is high for one cycle, in the cycle after the out_valid of a comparison that was presented with pop_req=1. pop_req without in_valid has no effect.
- R10: While rst_n is low at a clock edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 80 | First operand |
| op_b | input | 80 | Second operand |
| mode_unord | input | 1 | 1 selects unordered semantics, 0 selects ordered |
| pop_req | input | 1 | Request a stack pop after this comparison |
| out_valid | output | 1 | Result registered this cycle |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag (unordered) |
| cf | output | 1 | Carry flag (less or unordered) |
| cc_word | output | 16 | Legacy condition-code word |
| invalid | output | 1 | Invalid-operation flag |
| pop_strobe | output | 1 | One-cycle stack-pop strobe |

## Verification
The directed patterns each separate one part of the ordering:
- Pairs of finite values with the same sign show whether the magnitude compare is inverted correctly for negative numbers.
- Pairs with opposite signs and the two signed zeros show whether sign-only ordering and zero equality are handled.
- Infinities against large finite values check the top of the magnitude range.
- Quiet and signalling NaNs, sent in both modes, tell apart the four cases of the invalid flag.

A random stream mixes special values with finite ones, with copied operands and with back-to-back and idle cycles. It also contains pop requests without a valid strobe, which show whether the result register and the pop strobe track the valid strobe alone.

// File: rtl/fcmp_pkg.sv
// Package: shared types and constants for the floating-point compare flag unit.
// Assumes the 80-bit extended layout: sign, 15-bit exponent, 64-bit significand.
package fcmp_pkg;

    localparam int FP_EXP_W = 15;
    localparam int FP_SIG_W = 64;
    localparam int CC_W     = 16;
    localparam int CC_BIT_C0 = 8;
    localparam int CC_BIT_C2 = 10;
    localparam int CC_BIT_C3 = 14;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
    } opcls_t;

endpackage

// File: rtl/fcmp_classify.sv
// Module: classifies one operand as NaN, signalling NaN or zero.
// Assumes the significand MSB is the explicit integer bit and the next bit is
// the quiet bit. A NaN needs a maximal exponent and a nonzero fraction.
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int SIG_W = FP_SIG_W,
    localparam int OP_W = 1 + EXP_W + SIG_W
) (
    input  logic [OP_W-1:0] op,
    output opcls_t          cls
);

    logic [EXP_W-1:0] exp_f;
    logic [SIG_W-1:0] sig_f;
    logic             frac_nz;
    logic             exp_max;

    // Split the operand into fields and derive the class bits.
    always_comb begin
        exp_f       = op[SIG_W +: EXP_W];
        sig_f       = op[SIG_W-1:0];
        frac_nz     = |sig_f[SIG_W-2:0];
        exp_max     = &exp_f;
        cls.is_nan  = exp_max && frac_nz;
        cls.is_snan = exp_max && frac_nz && !sig_f[SIG_W-2];
        cls.is_zero = (exp_f == '0) && (sig_f == '0);
    end

endmodule

// File: rtl/fcmp_order.sv
// Module: decides the four-way relation between two classified operands.
// Assumes the class bits come from fcmp_classify. Magnitudes compare as
// exponent followed by significand, which equals the raw bits below the sign.
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int SIG_W = FP_SIG_W,
    localparam int OP_W = 1 + EXP_W + SIG_W
) (
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  opcls_t          cls_a,
    input  opcls_t          cls_b,
    output rel_e            rel
);

    logic [OP_W-2:0] mag_a;
    logic [OP_W-2:0] mag_b;
    logic            sgn_a;
    logic            sgn_b;

    // Select the relation: NaN first, then zeros, then sign, then magnitude.
    always_comb begin
        mag_a = op_a[OP_W-2:0];
        mag_b = op_b[OP_W-2:0];
        sgn_a = op_a[OP_W-1];
        sgn_b = op_b[OP_W-1];
        if (cls_a.is_nan || cls_b.is_nan)
            rel = REL_UN;
        else if (cls_a.is_zero && cls_b.is_zero)
            rel = REL_EQ;
        else if (sgn_a != sgn_b)
            rel = sgn_a ? REL_LT : REL_GT;
        else if (mag_a == mag_b)
            rel = REL_EQ;
        else if ((mag_a > mag_b) ^ sgn_a)
            rel = REL_GT;
        else
            rel = REL_LT;
    end

endmodule

// File: rtl/fcmp_flag_map.sv
// Module: maps a relation onto the zero/parity/carry flags and the legacy
// condition-code word. Bit positions come from parameters.
// Assumes unused bits of the word read as zero.
module fcmp_flag_map
    import fcmp_pkg::*;
#(
    parameter int STAT_W = CC_W,
    parameter int POS_C0 = CC_BIT_C0,
    parameter int POS_C2 = CC_BIT_C2,
    parameter int POS_C3 = CC_BIT_C3
) (
    input  rel_e              rel,
    output logic              zf_n,
    output logic              pf_n,
    output logic              cf_n,
    output logic [STAT_W-1:0] cc_n
);

    // Decode the relation into the three flags.
    always_comb begin
        unique case (rel)
            REL_GT:  {zf_n, pf_n, cf_n} = 3'b000;
            REL_LT:  {zf_n, pf_n, cf_n} = 3'b001;
            REL_EQ:  {zf_n, pf_n, cf_n} = 3'b100;
            default: {zf_n, pf_n, cf_n} = 3'b111;
        endcase
    end

    // Place each flag into its position in the status word.
    for (genvar i = 0; i < STAT_W; i++) begin : g_cc
        if (i == POS_C0) begin : g_c0
            assign cc_n[i] = cf_n;
        end else if (i == POS_C2) begin : g_c2
            assign cc_n[i] = pf_n;
        end else if (i == POS_C3) begin : g_c3
            assign cc_n[i] = zf_n;
        end else begin : g_zero
            assign cc_n[i] = 1'b0;
        end
    end

endmodule

// File: rtl/fcmp_flag_unit.sv
// Module: top of the compare flag unit. It classifies both operands, orders
// them, maps the result to flags and registers everything one cycle after
// in_valid. A pop request produces a strobe one cycle after the result.
// Assumes a synchronous active-low reset.
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int SIG_W  = FP_SIG_W,
    parameter int STAT_W = CC_W,
    localparam int OP_W  = 1 + EXP_W + SIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic              mode_unord,
    input  logic              pop_req,
    output logic              out_valid,
    output logic              zf,
    output logic              pf,
    output logic              cf,
    output logic [STAT_W-1:0] cc_word,
    output logic              invalid,
    output logic              pop_strobe
);

    opcls_t            cls_a;
    opcls_t            cls_b;
    rel_e              rel;
    logic              zf_n;
    logic              pf_n;
    logic              cf_n;
    logic [STAT_W-1:0] cc_n;
    logic              inv_n;
    logic              pop_pend;

    fcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls_a (
        .op  (op_a),
        .cls (cls_a)
    );

    fcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls_b (
        .op  (op_b),
        .cls (cls_b)
    );

    fcmp_order #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_order (
        .op_a  (op_a),
        .op_b  (op_b),
        .cls_a (cls_a),
        .cls_b (cls_b),
        .rel   (rel)
    );

    fcmp_flag_map #(.STAT_W(STAT_W)) u_map (
        .rel  (rel),
        .zf_n (zf_n),
        .pf_n (pf_n),
        .cf_n (cf_n),
        .cc_n (cc_n)
    );

    // Raise invalid on unordered results: always in ordered mode, only for SNaN otherwise.
    always_comb begin
        inv_n = (rel == REL_UN) && (!mode_unord || cls_a.is_snan || cls_b.is_snan);
    end

    // Register the flags and word on a valid strobe; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zf      <= 1'b0;
            pf      <= 1'b0;
            cf      <= 1'b0;
            cc_word <= '0;
            invalid <= 1'b0;
        end else if (in_valid) begin
            zf      <= zf_n;
            pf      <= pf_n;
            cf      <= cf_n;
            cc_word <= cc_n;
            invalid <= inv_n;
        end
    end

    // Generate the one-cycle result valid and the delayed pop strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            pop_pend   <= 1'b0;
            pop_strobe <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            pop_pend   <= in_valid && pop_req;
            pop_strobe <= pop_pend;
        end
    end

endmodule

// File: rtl/fcmp_flag_unit_chk.sv
// Module: assertion checker for fcmp_flag_unit, attached by bind.
// Assumes the default 16-bit condition-code word layout from fcmp_pkg.
module fcmp_flag_unit_chk
    import fcmp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            pop_req,
    input logic            out_valid,
    input logic            zf,
    input logic            pf,
    input logic            cf,
    input logic [CC_W-1:0] cc_word,
    input logic            invalid,
    input logic            pop_strobe
);

    localparam logic [CC_W-1:0] CC_USED =
        (CC_W'(1) << CC_BIT_C0) | (CC_W'(1) << CC_BIT_C2) | (CC_W'(1) << CC_BIT_C3);

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid))); // R8

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable({zf, pf, cf, invalid, cc_word})); // R8

    AST_UNORD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        pf |-> (zf && cf)); // R4

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(zf && cf && !pf)); // R3

    AST_CC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_word[CC_BIT_C0] == cf) && (cc_word[CC_BIT_C2] == pf) &&
        (cc_word[CC_BIT_C3] == zf) && ((cc_word & ~CC_USED) == '0)); // R7

    AST_INVALID_NEEDS_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> pf); // R5

    AST_POP_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        pop_strobe |-> ($past(out_valid) && $past(pop_req, 2) && $past(in_valid, 2))); // R9

endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .pop_req    (pop_req),
    .out_valid  (out_valid),
    .zf         (zf),
    .pf         (pf),
    .cf         (cf),
    .cc_word    (cc_word),
    .invalid    (invalid),
    .pop_strobe (pop_strobe)
);

// File: tb/tb_fcmp_flag_unit.sv
`timescale 1ns/1ps
module tb_fcmp_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [79:0] op_a = '0;
    logic [79:0] op_b = '0;
    logic        mode_unord = 1'b0;
    logic        pop_req = 1'b0;
    logic        out_valid;
    logic        zf;
    logic        pf;
    logic        cf;
    logic [15:0] cc_word;
    logic        invalid;
    logic        pop_strobe;

    int checks = 0;
    int failures = 0;
    bit active = 1'b0;

    always #2.5 clk = ~clk;

    fcmp_flag_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_a       (op_a),
        .op_b       (op_b),
        .mode_unord (mode_unord),
        .pop_req    (pop_req),
        .out_valid  (out_valid),
        .zf         (zf),
        .pf         (pf),
        .cf         (cf),
        .cc_word    (cc_word),
        .invalid    (invalid),
        .pop_strobe (pop_strobe)
    );

    localparam logic [79:0] P_ONE  = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] P_TWO  = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
    localparam logic [79:0] N_ONE  = {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] N_TWO  = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};
    localparam logic [79:0] P_ZERO = 80'd0;
    localparam logic [79:0] N_ZERO = {1'b1, 79'd0};
    localparam logic [79:0] P_INF  = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] N_INF  = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] P_BIG  = {1'b0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [79:0] QNAN   = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000};
    localparam logic [79:0] SNAN   = {1'b1, 15'h7FFF, 64'hA000_0000_0000_0001};
    localparam logic [79:0] P_ONE_U = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0001};

    // Reference helpers: signed key ordering, independent of field-level compare.
    function automatic bit is_nan_ref(input logic [79:0] v);
        return (v[78:64] == 15'h7FFF) && (v[62:0] != 63'd0);
    endfunction

    function automatic bit is_snan_ref(input logic [79:0] v);
        return (v[78:64] == 15'h7FFF) && !v[62] && (v[61:0] != 62'd0);
    endfunction

    function automatic int rel_ref(input logic [79:0] a, input logic [79:0] b);
        logic signed [81:0] ka;
        logic signed [81:0] kb;
        if (is_nan_ref(a) || is_nan_ref(b)) return 3;
        ka = a[79] ? -$signed({3'b000, a[78:0]}) : $signed({3'b000, a[78:0]});
        kb = b[79] ? -$signed({3'b000, b[78:0]}) : $signed({3'b000, b[78:0]});
        if (ka > kb) return 0;
        if (ka < kb) return 1;
        return 2;
    endfunction

    // Reference model state, updated at each rising edge.
    logic m_valid = 0, m_zf = 0, m_pf = 0, m_cf = 0, m_inv = 0, m_pend = 0, m_pop = 0;
    logic m_mode = 0;
    int   m_rel = 2;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 0; m_zf <= 0; m_pf <= 0; m_cf <= 0; m_inv <= 0;
            m_pend <= 0; m_pop <= 0;
        end else begin
            m_valid <= in_valid;
            m_pend  <= in_valid && pop_req;
            m_pop   <= m_pend;
            if (in_valid) begin
                int r;
                r = rel_ref(op_a, op_b);
                m_rel  <= r;
                m_mode <= mode_unord;
                m_zf   <= (r == 2) || (r == 3);
                m_pf   <= (r == 3);
                m_cf   <= (r == 1) || (r == 3);
                m_inv  <= (r == 3) && (!mode_unord || is_snan_ref(op_a) || is_snan_ref(op_b));
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, sampled on the falling edge.
    always @(negedge clk) begin
        if (active) begin
            string ftag;
            logic [15:0] exp_cc;
            ftag = (m_rel == 0) ? "R1" : (m_rel == 1) ? "R2" : (m_rel == 2) ? "R3" : "R4";
            exp_cc = 16'd0;
            exp_cc[8] = m_cf; exp_cc[10] = m_pf; exp_cc[14] = m_zf;
            check(out_valid === m_valid, "R8", "out_valid", 32'(out_valid), 32'(m_valid));
            check({zf, pf, cf} === {m_zf, m_pf, m_cf}, ftag, "zf/pf/cf",
                  32'({zf, pf, cf}), 32'({m_zf, m_pf, m_cf}));
            check(cc_word === exp_cc, "R7", "cc_word", 32'(cc_word), 32'(exp_cc));
            check(invalid === m_inv, m_mode ? "R6" : "R5", "invalid",
                  32'(invalid), 32'(m_inv));
            check(pop_strobe === m_pop, "R9", "pop_strobe", 32'(pop_strobe), 32'(m_pop));
        end
    end

    task automatic send(input logic [79:0] a, input logic [79:0] b,
                        input logic mode, input logic pop);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; mode_unord = mode; pop_req = pop;
    endtask

    task automatic idle(input int n, input logic pop);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; pop_req = pop;
            op_a = {$urandom, $urandom, $urandom};
            op_b = {$urandom, $urandom, $urandom};
        end
    endtask

    function automatic logic [79:0] rnd_op();
        int k;
        k = $urandom % 10;
        case (k)
            0: return {1'($urandom), 79'd0};
            1: return {1'($urandom), 15'h7FFF, 2'b11, 62'($urandom)};
            2: return {1'($urandom), 15'h7FFF, 2'b10, 61'($urandom), 1'b1};
            3: return {1'($urandom), 15'h7FFF, 64'h8000_0000_0000_0000};
            4: return {1'($urandom), 15'h3FFF, 63'h4000_0000_0000_0000 | 63'($urandom % 4), 1'b0};
            default: return {1'($urandom), 15'($urandom % 16'h7FFF), 1'b1, 31'($urandom), 32'($urandom)};
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: outputs cleared while reset is held
        check({out_valid, zf, pf, cf, invalid, pop_strobe, cc_word} === 22'd0, "R10",
              "reset outputs", 32'({out_valid, zf, pf, cf, invalid, pop_strobe, cc_word}), 32'd0);
        rst_n = 1'b1;
        active = 1'b1;
        idle(2, 1'b0);

        send(P_TWO, P_ONE, 1'b0, 1'b0);   // R1 positive greater
        send(N_ONE, N_TWO, 1'b0, 1'b0);   // R1 negative magnitudes inverted
        send(P_ONE, P_ONE_U, 1'b0, 1'b0); // R2 last significand bit
        send(N_ONE, P_ONE, 1'b0, 1'b1);   // R2 sign decides, with pop R9
        idle(3, 1'b0);
        send(P_ZERO, N_ZERO, 1'b0, 1'b0); // R3 signed zeros
        send(P_ONE, P_ONE, 1'b1, 1'b0);   // R3 identical
        send(P_INF, P_BIG, 1'b0, 1'b0);   // R1 infinity above largest
        send(N_INF, N_ZERO, 1'b0, 1'b0);  // R2
        send(QNAN, P_ONE, 1'b0, 1'b0);    // R4 R5 ordered qnan invalid
        send(P_ONE, QNAN, 1'b1, 1'b0);    // R6 quiet in unordered mode
        send(SNAN, P_ONE, 1'b1, 1'b1);    // R6 signalling in unordered mode
        send(QNAN, SNAN, 1'b1, 1'b0);     // R6
        send(P_INF, N_INF, 1'b1, 1'b0);   // R1 infinity is ordered
        idle(4, 1'b1);                    // R9 pop_req without valid
        send(P_ONE, P_TWO, 1'b0, 1'b1);
        send(P_TWO, P_ONE, 1'b0, 1'b1);   // back-to-back pops
        idle(5, 1'b0);                    // R8 flags hold

        for (int i = 0; i < 400; i++) begin
            logic [79:0] a;
            logic [79:0] b;
            a = rnd_op();
            b = ($urandom % 6 == 0) ? a : rnd_op();
            send(a, b, 1'($urandom), 1'($urandom % 3 == 0));
            if ($urandom % 3 == 0) idle(1 + $urandom % 3, 1'($urandom));
        end
        idle(4, 1'b0);
        active = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule